// File: doc/BRIEF.md
# Memory Security Attribution Unit

This block assigns one of three security levels to every 32-bit bus address: Secure (S), Non-secure-Callable (NSC) or Non-secure (NS). Two sources feed the decision. A hardwired address map cannot be changed. It marks the secure aliases of code, SRAM and peripherals as NSC and everything else as NS. A software table of programmable regions gives a second result. Each region is a base/limit range at 32-byte granularity with its own enable and NSC flag. The block reports the stricter of the two results, using the order S > NSC > NS.

Software fills the table through a single-cycle write port and then sets a global enable. Until that happens, and after every reset, the table resolves every address to S, so the whole map stays Secure. A TrustZone enable input turns the mechanism off: while it is low, every address resolves to NS. The lookup is purely combinational from the address and the registered table. A write is visible on the cycle after its strobe.

Top module: `secattr_unit`

## Requirements
- R1: After reset, with `tz_en_i` high, every address resolves to S (encoding 2'b10) and `region_valid_o` is 0, until the global enable is written.
- R2: While `tz_en_i` is low, `attr_o` is NS (2'b00), `region_valid_o` is 0 and `region_o` is 0 for any address and any table contents.
- R3: Addresses 0x0C00_0000–0x0FFF_FFFF, 0x3000_0000–0x3FFF_FFFF and 0x5000_0000–0x5FFF_FFFF are never weaker than NSC (2'b01) when `tz_en_i` is high, even when the table says NS.
- R4: In every other window, including the external memory ranges and the NS aliases at 0x0800_0000, 0x2000_0000 and 0x4000_0000, the hardwired map contributes NS. The final result there equals the table result.
- R5: An enabled region matches when base ≤ addr[31:5] ≤ limit, with both bounds inclusive. addr[4:0] has no effect.
- R6: An address that matches exactly one enabled region gets the table result NSC when that region's NSC flag is set, and NS otherwise.
- R7: With the global enable set, an address that matches no enabled region gets S. A region whose enable bit is 0 never matches.
- R8: An address that matches two or more enabled regions gets S, and `region_valid_o` is 0.
- R9: Write map, indexed by `wr_idx_i`. Index 2i is region i's base word: bits [31:5] hold the base and bit 0 holds the region enable. Index 2i+1 is its limit word: bits [31:5] hold the limit and bit 1 holds the NSC flag. Index 2·NUM_REGIONS is the control word, where bit 0 is the global enable. Any higher index is ignored. A write changes the lookup on the cycle after the strobe.
- R10: `region_valid_o` is 1 exactly when `tz_en_i` is high, the global enable is set and exactly one enabled region matches. `region_o` then carries that region's number, and otherwise it is 0.
- R11: The final attribution is the stricter of the hardwired result and the table result, using the order S > NSC > NS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tz_en_i | input | 1 | TrustZone enable; low forces NS |
| lookup_addr_i | input | 32 | Address to attribute |
| wr_en_i | input | 1 | Table write strobe |
| wr_idx_i | input | $clog2(2*NUM_REGIONS+1) | Word index for the write |
| wr_data_i | input | 32 | Write data |
| attr_o | output | 2 | Final attribution: 00 NS, 01 NSC, 10 S |
| region_o | output | max(1,$clog2(NUM_REGIONS)) | Number of the matched region |
| region_valid_o | output | 1 | Exactly one enabled region matched |

## Verification
The bench builds the block with the default NUM_REGIONS of 8. The write index is then 5 bits wide, so the control word at index 16 sits beside the unused indices 17–31, and the bench writes to one of those unused indices to show it is ignored. With eight regions, the bench can keep the lowest region (0) and a middle region (3, 4) live at the same time. This covers single matches, overlaps between a low and a higher region, and a region that is disabled after use. Each case runs against both the hardwired NSC aliases and the unaliased windows.

// File: rtl/sec_attr_pkg.sv
package sec_attr_pkg;

  // Numeric order equals strictness order, so the stricter result is the larger value.
  typedef enum logic [1:0] {
    ATTR_NS  = 2'b00,
    ATTR_NSC = 2'b01,
    ATTR_S   = 2'b10
  } attr_e;

  localparam int unsigned GRAN_LSB = 5;
  localparam int unsigned PAGE_W   = 32 - GRAN_LSB;

  typedef struct packed {
    logic              en;
    logic              nsc;
    logic [PAGE_W-1:0] base;
    logic [PAGE_W-1:0] limit;
  } region_t;

  function automatic attr_e attr_stricter(input attr_e a, input attr_e b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/secattr_rst_sync.sv
module secattr_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/secattr_fixed_map.sv
module secattr_fixed_map
  import sec_attr_pkg::*;
(
  input  logic [31:26] addr_hi_i,
  output attr_e        attr_o
);

  logic code_sec_alias;
  logic sram_sec_alias;
  logic peri_sec_alias;

  always_comb begin
    code_sec_alias = (addr_hi_i == 6'b000011);
    sram_sec_alias = (addr_hi_i[31:28] == 4'h3);
    peri_sec_alias = (addr_hi_i[31:28] == 4'h5);
    if (code_sec_alias || sram_sec_alias || peri_sec_alias) attr_o = ATTR_NSC;
    else                                                    attr_o = ATTR_NS;
  end

endmodule

// File: rtl/secattr_region_file.sv
module secattr_region_file
  import sec_attr_pkg::*;
#(
  parameter int unsigned NUM_REGIONS = 8,
  localparam int unsigned IDX_W      = $clog2(2*NUM_REGIONS+1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [31:0]      wr_data_i,
  output region_t          regions_o [NUM_REGIONS],
  output logic             glb_en_o
);

  localparam int unsigned CTRL_IDX = 2*NUM_REGIONS;

  region_t regions_q [NUM_REGIONS];
  region_t regions_d [NUM_REGIONS];
  logic    glb_en_q, glb_en_d;
  logic    unused_wr_bits;

  assign unused_wr_bits = ^wr_data_i[4:2];

  always_comb begin
    glb_en_d = glb_en_q;
    if (wr_en_i && (int'(wr_idx_i) == CTRL_IDX)) glb_en_d = wr_data_i[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       glb_en_q <= 1'b0;
    else if (wr_en_i) glb_en_q <= glb_en_d;
  end

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_region
    logic base_sel, limit_sel;

    always_comb begin
      base_sel     = wr_en_i && (int'(wr_idx_i) == 2*g);
      limit_sel    = wr_en_i && (int'(wr_idx_i) == 2*g+1);
      regions_d[g] = regions_q[g];
      if (base_sel) begin
        regions_d[g].base = wr_data_i[31:GRAN_LSB];
        regions_d[g].en   = wr_data_i[0];
      end
      if (limit_sel) begin
        regions_d[g].limit = wr_data_i[31:GRAN_LSB];
        regions_d[g].nsc   = wr_data_i[1];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     regions_q[g] <= '0;
      else if (base_sel || limit_sel) regions_q[g] <= regions_d[g];
    end

    assign regions_o[g] = regions_q[g];
  end

  assign glb_en_o = glb_en_q;

endmodule

// File: rtl/secattr_region_match.sv
module secattr_region_match
  import sec_attr_pkg::*;
#(
  parameter int unsigned NUM_REGIONS = 8,
  localparam int unsigned RID_W      = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1,
  localparam int unsigned CNT_W      = $clog2(NUM_REGIONS+1)
) (
  input  logic [PAGE_W-1:0] page_i,
  input  region_t           regions_i [NUM_REGIONS],
  input  logic              glb_en_i,
  output attr_e             attr_o,
  output logic [RID_W-1:0]  region_o,
  output logic              single_o
);

  logic [NUM_REGIONS-1:0] hit;
  logic [CNT_W-1:0]       hit_cnt;
  logic [RID_W-1:0]       first_idx;
  logic                   first_nsc;

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_cmp
    assign hit[g] = regions_i[g].en
                  && (page_i >= regions_i[g].base)
                  && (page_i <= regions_i[g].limit);
  end

  always_comb begin
    hit_cnt   = '0;
    first_idx = '0;
    first_nsc = 1'b0;
    for (int i = NUM_REGIONS-1; i >= 0; i--) begin
      if (hit[i]) begin
        hit_cnt   = hit_cnt + 1'b1;
        first_idx = RID_W'(i);
        first_nsc = regions_i[i].nsc;
      end
    end
  end

  always_comb begin
    attr_o   = ATTR_S;
    region_o = '0;
    single_o = 1'b0;
    if (glb_en_i && (hit_cnt == CNT_W'(1))) begin
      attr_o   = first_nsc ? ATTR_NSC : ATTR_NS;
      region_o = first_idx;
      single_o = 1'b1;
    end
  end

endmodule

// File: rtl/secattr_unit.sv
module secattr_unit
  import sec_attr_pkg::*;
#(
  parameter int unsigned NUM_REGIONS = 8,
  localparam int unsigned IDX_W      = $clog2(2*NUM_REGIONS+1),
  localparam int unsigned RID_W      = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tz_en_i,
  input  logic [31:0]      lookup_addr_i,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [31:0]      wr_data_i,
  output logic [1:0]       attr_o,
  output logic [RID_W-1:0] region_o,
  output logic             region_valid_o
);

  logic             rst_sync_n;
  region_t          regions [NUM_REGIONS];
  logic             glb_en;
  attr_e            fixed_attr;
  attr_e            table_attr;
  logic [RID_W-1:0] table_region;
  logic             table_single;
  logic             unused_low_addr;

  assign unused_low_addr = ^lookup_addr_i[GRAN_LSB-1:0];

  secattr_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  secattr_region_file #(.NUM_REGIONS(NUM_REGIONS)) u_file (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .wr_en_i   (wr_en_i),
    .wr_idx_i  (wr_idx_i),
    .wr_data_i (wr_data_i),
    .regions_o (regions),
    .glb_en_o  (glb_en)
  );

  secattr_fixed_map u_fixed (
    .addr_hi_i (lookup_addr_i[31:26]),
    .attr_o    (fixed_attr)
  );

  secattr_region_match #(.NUM_REGIONS(NUM_REGIONS)) u_match (
    .page_i    (lookup_addr_i[31:GRAN_LSB]),
    .regions_i (regions),
    .glb_en_i  (glb_en),
    .attr_o    (table_attr),
    .region_o  (table_region),
    .single_o  (table_single)
  );

  always_comb begin
    if (tz_en_i) begin
      attr_o         = attr_stricter(fixed_attr, table_attr);
      region_o       = table_region;
      region_valid_o = table_single;
    end else begin
      attr_o         = ATTR_NS;
      region_o       = '0;
      region_valid_o = 1'b0;
    end
  end

endmodule

// File: rtl/secattr_unit_chk.sv
module secattr_unit_chk #(
  parameter int unsigned NUM_REGIONS = 8,
  localparam int unsigned IDX_W      = $clog2(2*NUM_REGIONS+1),
  localparam int unsigned RID_W      = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tz_en_i,
  input logic [31:0]      lookup_addr_i,
  input logic             wr_en_i,
  input logic [IDX_W-1:0] wr_idx_i,
  input logic [31:0]      wr_data_i,
  input logic [1:0]       attr_o,
  input logic [RID_W-1:0] region_o,
  input logic             region_valid_o
);

  logic in_sec_alias;
  assign in_sec_alias = (lookup_addr_i >= 32'h0C00_0000 && lookup_addr_i < 32'h1000_0000)
                     || (lookup_addr_i >= 32'h3000_0000 && lookup_addr_i < 32'h4000_0000)
                     || (lookup_addr_i >= 32'h5000_0000 && lookup_addr_i < 32'h6000_0000);

  AST_TZ_OFF_NS: assert property (@(posedge clk) disable iff (!rst_n)
    !tz_en_i |-> (attr_o == 2'b00 && !region_valid_o)); // R2

  AST_ALIAS_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    (tz_en_i && in_sec_alias) |-> (attr_o != 2'b00)); // R3

  AST_VALID_NOT_SECURE: assert property (@(posedge clk) disable iff (!rst_n)
    region_valid_o |-> (attr_o != 2'b10)); // R10

  AST_INVALID_ZERO_ID: assert property (@(posedge clk) disable iff (!rst_n)
    !region_valid_o |-> (region_o == '0)); // R10

  AST_DISABLE_SECURE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && int'(wr_idx_i) == 2*NUM_REGIONS && wr_data_i == 32'h0)
      |=> (!tz_en_i || attr_o == 2'b10)); // R9

  AST_LEGAL_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    attr_o != 2'b11); // R11

endmodule

bind secattr_unit secattr_unit_chk #(.NUM_REGIONS(NUM_REGIONS)) u_chk (.*);

// File: tb/secattr_unit_test.sv
module secattr_unit_test;

  localparam int unsigned N     = 8;
  localparam int unsigned IDX_W = $clog2(2*N+1);
  localparam int unsigned RID_W = $clog2(N);
  localparam logic [1:0] NS = 2'b00, NSC = 2'b01, S = 2'b10;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             tz_en_i;
  logic [31:0]      lookup_addr_i;
  logic             wr_en_i;
  logic [IDX_W-1:0] wr_idx_i;
  logic [31:0]      wr_data_i;
  logic [1:0]       attr_o;
  logic [RID_W-1:0] region_o;
  logic             region_valid_o;

  int n_tests = 0;
  int n_fail  = 0;

  always #2 clk = ~clk;

  secattr_unit #(.NUM_REGIONS(N)) uut (.*);

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic wr(input int idx, input logic [31:0] data);
    @(negedge clk);
    wr_en_i = 1'b1; wr_idx_i = IDX_W'(idx); wr_data_i = data;
    @(negedge clk);
    wr_en_i = 1'b0; wr_data_i = '0;
  endtask

  task automatic set_region(input int r, input logic [31:0] lo, input logic [31:0] hi,
                            input logic en, input logic nsc);
    wr(2*r,   {lo[31:5], 4'b0, en});
    wr(2*r+1, {hi[31:5], 3'b0, nsc, 1'b0});
  endtask

  task automatic look(input string req, input logic [31:0] a, input logic [1:0] ea,
                      input logic ev, input int er);
    lookup_addr_i = a;
    #1;
    chk(req, 32'(attr_o), 32'(ea));
    chk(req, 32'(region_valid_o), 32'(ev));
    chk(req, 32'(region_o), 32'(er));
  endtask

  task automatic t_reset;
    tz_en_i = 1'b1;
    look("R1", 32'h2000_0000, S, 0, 0);
    look("R1", 32'h6000_0040, S, 0, 0);
    look("R1", 32'h0C00_0000, S, 0, 0);
  endtask

  task automatic t_tz_off;
    tz_en_i = 1'b0;
    look("R2", 32'h3000_0000, NS, 0, 0);
    look("R2", 32'h2000_0000, NS, 0, 0);
    tz_en_i = 1'b1;
  endtask

  task automatic t_basic;
    set_region(0, 32'h2000_0000, 32'h2000_0FE0, 1'b1, 1'b0);
    look("R9", 32'h2000_0000, S, 0, 0);  // table still off
    wr(2*N, 32'h1);
    look("R9", 32'h2000_0000, NS, 1, 0);
    look("R5", 32'h2000_0FFF, NS, 1, 0);
    look("R5", 32'h2000_001F, NS, 1, 0);
    look("R7", 32'h2000_1000, S, 0, 0);
    look("R7", 32'h1FFF_FFFF, S, 0, 0);
  endtask

  task automatic t_nsc_and_map;
    set_region(3, 32'h0000_1000, 32'h0000_1FE0, 1'b1, 1'b1);
    look("R6", 32'h0000_1800, NSC, 1, 3);
    set_region(1, 32'h3000_0000, 32'h3000_FFE0, 1'b1, 1'b0);
    look("R3", 32'h3000_0100, NSC, 1, 1);
    look("R11", 32'h3001_0000, S, 0, 0);
    set_region(2, 32'h6000_0000, 32'h6FFF_FFE0, 1'b1, 1'b0);
    look("R4", 32'h6800_0000, NS, 1, 2);
    set_region(5, 32'h0800_0000, 32'h0800_0FE0, 1'b1, 1'b1);
    look("R4", 32'h0800_0020, NSC, 1, 5);
  endtask

  task automatic t_overlap;
    set_region(4, 32'h2000_0800, 32'h2000_1FE0, 1'b1, 1'b1);
    look("R8", 32'h2000_0900, S, 0, 0);
    look("R10", 32'h2000_0100, NS, 1, 0);
    look("R10", 32'h2000_1800, NSC, 1, 4);
    wr(2*4, {32'h2000_0800 >> 5, 5'b0});   // region 4 enable cleared
    look("R7", 32'h2000_0900, NS, 1, 0);
    look("R7", 32'h2000_1800, S, 0, 0);
  endtask

  task automatic t_bad_index;
    wr(2*N+1, 32'h0);
    wr(31, 32'h0);
    look("R9", 32'h2000_0000, NS, 1, 0);
    wr(2*N, 32'h0);
    look("R1", 32'h2000_0000, S, 0, 0);
    look("R3", 32'h5000_0000, S, 0, 0);
  endtask

  initial begin
    #(4 * 200000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; tz_en_i = 1'b1; lookup_addr_i = '0;
    wr_en_i = 1'b0; wr_idx_i = '0; wr_data_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_tz_off();
    t_basic();
    t_nsc_and_map();
    t_overlap();
    t_bad_index();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule